// File: doc/BRIEF.md
# Chained Descriptor DMA Sequencer

This block walks a host-programmed chain of DMA descriptors for one transfer direction. The host writes a header word holding the number of descriptors, a traffic-class value for message interrupts and a loop-control flag. The sequencer then processes descriptors one at a time. For each descriptor it asks an external fetch agent to bring the descriptor in, then hands the descriptor number to an abstract transfer engine and waits for that engine to report completion.

The host reads back a set of status words over a simple address/read/write bus. These report the number of the descriptor most recently completed, whether any work is still outstanding, fixed identification fields, and a cycle count for the whole chain. The cycle count includes the time spent fetching descriptors. A separate saturating counter tallies end-to-end CRC errors reported by the application while forwarding of such errors is enabled.

With the loop flag set, the chain restarts at its first descriptor each time the last one finishes, and keeps doing so until the host clears the flag.

Top module: `cdma_sequencer`

## Requirements
- R1: Out of reset every readable word returns 0, except the status-high word, which holds only its fixed fields and the empty flag, and `msi_tc` is 0. Writing offset 0x00 while idle with a nonzero count in bits [15:0] accepts a header. Offset 0x00 then reads back count [15:0], traffic class [30:28] and loop flag [31], and `msi_tc` follows bits [30:28].
- R2: For each descriptor, `fetch_req` stays high until `fetch_ack` is sampled high. `xfer_start` is then high for exactly one cycle with `xfer_num` giving the descriptor number, counted from 1. The sequencer then waits for `xfer_done`.
- R3: Bits [15:0] of the status-high word (offset 0x20) hold the number of the most recently completed descriptor. The field reads 0 immediately after a header is accepted.
- R4: Bit 16 of the status-high word is 1 exactly when no chain is active. While that bit is 1, neither `fetch_req` nor `xfer_start` is asserted.
- R5: With the loop flag at 0, the sequencer returns to idle after the last descriptor completes.
- R6: With the loop flag at 1, the chain continues at descriptor 1 after the last descriptor completes. A write to offset 0x00 while a chain is running updates only bit 31, so clearing that bit ends the chain at the next completion of the last descriptor.
- R7: While a chain is running, bits other than bit 31 in a write to offset 0x00 have no effect. While idle, a header whose count is 0 is ignored entirely.
- R8: The word at offset 0x24 counts clock edges from the edge that accepts a header through the edge that registers the first completion of the last descriptor. It then holds that value, including in loop mode. It is cleared by the next accepted header and saturates at all ones.
- R9: The status-high word has the version number (default 1) in bits [31:28] and the payload-size code (default 001 = 256 bytes) in bits [23:21]. The payload-size encoding is 000=128, 001=256, 010=512, 011=1024 and 100=2048 bytes. Bits [27:24] and [20:17] read 0.
- R10: Bits [15:0] of offset 0x30 increase by one on every cycle where `ecrc_err` and `ecrc_fwd_en` are both high, and saturate at 0xFFFF. Bits [31:16] read 0.
- R11: Writes to the status offsets are ignored. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_addr | input | 8 | Host byte offset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe; read data is combinational |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, 0 when not reading |
| fetch_req | output | 1 | Request the current descriptor from the fetch agent |
| fetch_ack | input | 1 | Descriptor fetch completed |
| xfer_start | output | 1 | One-cycle start pulse to the transfer engine |
| xfer_num | output | 16 | Descriptor number being started, counted from 1 |
| xfer_done | input | 1 | Transfer engine finished the current descriptor |
| msi_tc | output | 3 | Traffic class for interrupt messages |
| ecrc_err | input | 1 | End-to-end CRC error pulse |
| ecrc_fwd_en | input | 1 | Enables counting of CRC errors |

## Verification
The bound checker watches the handshake on every cycle. It confirms that the fetch request holds until acknowledged, that the start pulse lasts one cycle, directly follows an acknowledge and carries a number within the programmed count, and that nothing is requested while idle. It also confirms that the cycle and error counters never wrap and that the error counter moves only when both of its inputs are high. Only the directed scenarios can show the chain-level outcomes. These are the exact cycle total against edges counted by the bench, the loop restart at descriptor 1 and its termination after the flag is cleared, the way header writes during a run are ignored, and the readback values of every status field.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

   localparam int HADDR_W = 8;
   localparam int HDATA_W = 32;

   localparam logic [HADDR_W-1:0] OFS_CTRL    = 8'h00;
   localparam logic [HADDR_W-1:0] OFS_STAT_HI = 8'h20;
   localparam logic [HADDR_W-1:0] OFS_STAT_LO = 8'h24;
   localparam logic [HADDR_W-1:0] OFS_ERRCNT  = 8'h30;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_FETCH = 2'd1,
      SQ_START = 2'd2,
      SQ_WAIT  = 2'd3
   } seq_state_e;

   typedef struct packed {
      logic        loop;
      logic [2:0]  tc;
      logic [11:0] rsvd;
      logic [15:0] count;
   } ctrl_word_t;

endpackage

// File: rtl/cdma_sat_counter.sv
module cdma_sat_counter #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] value
);

   logic [W-1:0] cnt_q;
   logic         step;

   generate
      if (SATURATE) begin : g_sat
         assign step = inc && !(&cnt_q);
      end else begin : g_wrap
         assign step = inc;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign value = cnt_q;

endmodule

// File: rtl/cdma_chain_fsm.sv
module cdma_chain_fsm
   import cdma_pkg::*;
#(
   parameter int NUM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hdr_accept,
   input  logic [NUM_W-1:0] cfg_count,
   input  logic             cfg_loop,
   input  logic             fetch_ack,
   input  logic             xfer_done,
   output logic             fetch_req,
   output logic             xfer_start,
   output logic [NUM_W-1:0] xfer_num,
   output logic [NUM_W-1:0] last_done,
   output logic             busy,
   output logic             pass_end
);

   seq_state_e       state_q;
   logic [NUM_W-1:0] idx_q;
   logic [NUM_W-1:0] done_q;
   logic             at_last;

   localparam logic [NUM_W-1:0] FIRST_NUM = NUM_W'(1);

   assign at_last  = (idx_q == cfg_count);
   assign pass_end = (state_q == SQ_WAIT) && xfer_done && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         idx_q   <= '0;
         done_q  <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (hdr_accept) begin
                  state_q <= SQ_FETCH;
                  idx_q   <= FIRST_NUM;
                  done_q  <= '0;
               end
            end
            SQ_FETCH: begin
               if (fetch_ack) begin
                  state_q <= SQ_START;
               end
            end
            SQ_START: begin
               state_q <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (xfer_done) begin
                  done_q <= idx_q;
                  if (!at_last) begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= SQ_FETCH;
                  end else if (cfg_loop) begin
                     idx_q   <= FIRST_NUM;
                     state_q <= SQ_FETCH;
                  end else begin
                     state_q <= SQ_IDLE;
                  end
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign fetch_req  = (state_q == SQ_FETCH);
   assign xfer_start = (state_q == SQ_START);
   assign xfer_num   = idx_q;
   assign last_done  = done_q;
   assign busy       = (state_q != SQ_IDLE);

endmodule

// File: rtl/cdma_host_regs.sv
module cdma_host_regs
   import cdma_pkg::*;
#(
   parameter int         NUM_W    = 16,
   parameter int         PERF_W   = 32,
   parameter int         ERR_W    = 16,
   parameter logic [3:0] VERSION  = 4'h1,
   parameter logic [2:0] MPS_CODE = 3'b001
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [HADDR_W-1:0] hst_addr,
   input  logic               hst_wr,
   input  logic               hst_rd,
   input  logic [HDATA_W-1:0] hst_wdata,
   output logic [HDATA_W-1:0] hst_rdata,
   input  logic               busy,
   input  logic [NUM_W-1:0]   last_done,
   input  logic [PERF_W-1:0]  perf_val,
   input  logic [ERR_W-1:0]   ecrc_val,
   output logic               hdr_accept,
   output logic [NUM_W-1:0]   cfg_count,
   output logic               cfg_loop,
   output logic [2:0]         cfg_tc
);

   ctrl_word_t         ctrl_q;
   ctrl_word_t         wr_word;
   logic               wr_ctrl;
   logic [HDATA_W-1:0] stat_hi;
   logic [HDATA_W-1:0] rd_mux;

   assign wr_word    = ctrl_word_t'(hst_wdata);
   assign wr_ctrl    = hst_wr && (hst_addr == OFS_CTRL);
   assign hdr_accept = wr_ctrl && !busy && (|wr_word.count[NUM_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (hdr_accept) begin
         ctrl_q.loop  <= wr_word.loop;
         ctrl_q.tc    <= wr_word.tc;
         ctrl_q.rsvd  <= '0;
         ctrl_q.count <= 16'(wr_word.count[NUM_W-1:0]);
      end else if (wr_ctrl && busy) begin
         ctrl_q.loop  <= wr_word.loop;
      end
   end

   assign cfg_count = ctrl_q.count[NUM_W-1:0];
   assign cfg_loop  = ctrl_q.loop;
   assign cfg_tc    = ctrl_q.tc;

   assign stat_hi = {VERSION, 4'b0000, MPS_CODE, 4'b0000, !busy, 16'(last_done)};

   always_comb begin
      unique case (hst_addr)
         OFS_CTRL:    rd_mux = HDATA_W'(ctrl_q);
         OFS_STAT_HI: rd_mux = stat_hi;
         OFS_STAT_LO: rd_mux = HDATA_W'(perf_val);
         OFS_ERRCNT:  rd_mux = HDATA_W'(ecrc_val);
         default:     rd_mux = '0;
      endcase
   end

   assign hst_rdata = hst_rd ? rd_mux : '0;

endmodule

// File: rtl/cdma_sequencer.sv
module cdma_sequencer
   import cdma_pkg::*;
#(
   parameter int         NUM_W    = 16,
   parameter int         PERF_W   = 32,
   parameter int         ERR_W    = 16,
   parameter logic [3:0] VERSION  = 4'h1,
   parameter logic [2:0] MPS_CODE = 3'b001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       hst_addr,
   input  logic             hst_wr,
   input  logic             hst_rd,
   input  logic [31:0]      hst_wdata,
   output logic [31:0]      hst_rdata,
   output logic             fetch_req,
   input  logic             fetch_ack,
   output logic             xfer_start,
   output logic [NUM_W-1:0] xfer_num,
   input  logic             xfer_done,
   output logic [2:0]       msi_tc,
   input  logic             ecrc_err,
   input  logic             ecrc_fwd_en
);

   generate
      if (NUM_W < 1 || NUM_W > 16) begin : g_bad_num
         $error("NUM_W must lie in 1..16");
      end
      if (PERF_W < 1 || PERF_W > HDATA_W) begin : g_bad_perf
         $error("PERF_W must lie in 1..32");
      end
      if (ERR_W < 1 || ERR_W > 16) begin : g_bad_err
         $error("ERR_W must lie in 1..16");
      end
      if (MPS_CODE > 3'b100) begin : g_bad_mps
         $error("MPS_CODE must not exceed 3'b100");
      end
   endgenerate

   logic             hdr_accept;
   logic [NUM_W-1:0] cfg_count;
   logic             cfg_loop;
   logic             busy;
   logic             pass_end;
   logic [NUM_W-1:0] last_done;
   logic [PERF_W-1:0] perf_val;
   logic [ERR_W-1:0] ecrc_val;
   logic             timing_q;

   cdma_host_regs #(
      .NUM_W    (NUM_W),
      .PERF_W   (PERF_W),
      .ERR_W    (ERR_W),
      .VERSION  (VERSION),
      .MPS_CODE (MPS_CODE)
   ) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .hst_addr   (hst_addr),
      .hst_wr     (hst_wr),
      .hst_rd     (hst_rd),
      .hst_wdata  (hst_wdata),
      .hst_rdata  (hst_rdata),
      .busy       (busy),
      .last_done  (last_done),
      .perf_val   (perf_val),
      .ecrc_val   (ecrc_val),
      .hdr_accept (hdr_accept),
      .cfg_count  (cfg_count),
      .cfg_loop   (cfg_loop),
      .cfg_tc     (msi_tc)
   );

   cdma_chain_fsm #(
      .NUM_W (NUM_W)
   ) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .hdr_accept (hdr_accept),
      .cfg_count  (cfg_count),
      .cfg_loop   (cfg_loop),
      .fetch_ack  (fetch_ack),
      .xfer_done  (xfer_done),
      .fetch_req  (fetch_req),
      .xfer_start (xfer_start),
      .xfer_num   (xfer_num),
      .last_done  (last_done),
      .busy       (busy),
      .pass_end   (pass_end)
   );

   // chain timing window: opened by header acceptance, closed by first pass end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timing_q <= 1'b0;
      end else if (hdr_accept) begin
         timing_q <= 1'b1;
      end else if (pass_end) begin
         timing_q <= 1'b0;
      end
   end

   cdma_sat_counter #(
      .W        (PERF_W),
      .SATURATE (1'b1)
   ) perf_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hdr_accept),
      .inc   (timing_q),
      .value (perf_val)
   );

   cdma_sat_counter #(
      .W        (ERR_W),
      .SATURATE (1'b1)
   ) ecrc_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (1'b0),
      .inc   (ecrc_err && ecrc_fwd_en),
      .value (ecrc_val)
   );

endmodule

// File: rtl/cdma_sequencer_chk.sv
module cdma_sequencer_chk #(
   parameter int NUM_W  = 16,
   parameter int PERF_W = 32,
   parameter int ERR_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_req,
   input logic              fetch_ack,
   input logic              xfer_start,
   input logic [NUM_W-1:0]  xfer_num,
   input logic              ecrc_err,
   input logic              ecrc_fwd_en,
   input logic              busy,
   input logic [NUM_W-1:0]  cfg_count,
   input logic [PERF_W-1:0] perf_val,
   input logic [ERR_W-1:0]  ecrc_val
);

   p_fetch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_ack) |=> fetch_req);

   p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start);

   p_start_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> $past(fetch_req && fetch_ack));

   p_num_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> (xfer_num != '0 && xfer_num <= cfg_count));

   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!fetch_req && !xfer_start));

   p_perf_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (&perf_val) |=> ((&perf_val) || perf_val == '0));

   p_ecrc_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ecrc_err && ecrc_fwd_en) |=> $stable(ecrc_val));

   p_ecrc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ecrc_err && ecrc_fwd_en && !(&ecrc_val)) |=> (ecrc_val == ERR_W'($past(ecrc_val) + 1'b1)));

   p_ecrc_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (&ecrc_val) |=> (&ecrc_val));

endmodule

bind cdma_sequencer cdma_sequencer_chk #(
   .NUM_W  (NUM_W),
   .PERF_W (PERF_W),
   .ERR_W  (ERR_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_req   (fetch_req),
   .fetch_ack   (fetch_ack),
   .xfer_start  (xfer_start),
   .xfer_num    (xfer_num),
   .ecrc_err    (ecrc_err),
   .ecrc_fwd_en (ecrc_fwd_en),
   .busy        (busy),
   .cfg_count   (cfg_count),
   .perf_val    (perf_val),
   .ecrc_val    (ecrc_val)
);

// File: tb/cdma_sequencer_tb_top.sv
module cdma_sequencer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  hst_addr = '0;
   logic        hst_wr = 1'b0;
   logic        hst_rd = 1'b0;
   logic [31:0] hst_wdata = '0;
   logic [31:0] hst_rdata;
   logic        fetch_req;
   logic        fetch_ack = 1'b0;
   logic        xfer_start;
   logic [15:0] xfer_num;
   logic        xfer_done = 1'b0;
   logic [2:0]  msi_tc;
   logic        ecrc_err = 1'b0;
   logic        ecrc_fwd_en = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int wr_cyc = 0;
   int done_cyc = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cdma_sequencer dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .hst_addr    (hst_addr),
      .hst_wr      (hst_wr),
      .hst_rd      (hst_rd),
      .hst_wdata   (hst_wdata),
      .hst_rdata   (hst_rdata),
      .fetch_req   (fetch_req),
      .fetch_ack   (fetch_ack),
      .xfer_start  (xfer_start),
      .xfer_num    (xfer_num),
      .xfer_done   (xfer_done),
      .msi_tc      (msi_tc),
      .ecrc_err    (ecrc_err),
      .ecrc_fwd_en (ecrc_fwd_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
      @(negedge clk);
      hst_wr = 1'b0;
      wr_cyc = cyc;
   endtask

   task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      hst_addr = a; hst_rd = 1'b1;
      #1 d = hst_rdata;
      hst_rd = 1'b0;
   endtask

   // serve one descriptor: fetch handshake, start check, completion
   task automatic serve_desc(input int exp_num, input string req);
      int waited = 0;
      @(negedge clk);
      while (!fetch_req && waited < 50) begin
         @(negedge clk);
         waited++;
      end
      check({req, " fetch_req raised"}, 32'(fetch_req), 32'd1);
      @(negedge clk);
      check("R2 fetch_req held without ack", 32'(fetch_req), 32'd1);
      fetch_ack = 1'b1;
      @(negedge clk);
      fetch_ack = 1'b0;
      check("R2 xfer_start after ack", 32'(xfer_start), 32'd1);
      check({req, " xfer_num"}, 32'(xfer_num), 32'(exp_num));
      @(negedge clk);
      check("R2 xfer_start one cycle", 32'(xfer_start), 32'd0);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      done_cyc = cyc;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      reg_rd(8'h00, d);  check("R1 reset ctrl", d, 32'h0);
      reg_rd(8'h20, d);  check("R1 R9 reset status hi", d, 32'h1021_0000);
      reg_rd(8'h24, d);  check("R1 reset perf", d, 32'h0);
      reg_rd(8'h30, d);  check("R1 reset err count", d, 32'h0);
      check("R1 reset msi_tc", 32'(msi_tc), 32'd0);
      check("R4 reset fetch_req", 32'(fetch_req), 32'd0);
   endtask

   task automatic t_single_pass();
      logic [31:0] d;
      int a_cyc;
      reg_wr(8'h00, 32'h5000_0003);
      a_cyc = wr_cyc;
      reg_rd(8'h00, d);  check("R1 ctrl readback", d, 32'h5000_0003);
      check("R1 msi_tc follows header", 32'(msi_tc), 32'd5);
      reg_rd(8'h20, d);  check("R4 empty low while running", d, 32'h1020_0000);
      serve_desc(1, "R2 single d1");
      reg_rd(8'h20, d);  check("R3 last done after first", d & 32'hFFFF, 32'd1);
      serve_desc(2, "R2 single d2");
      serve_desc(3, "R2 single d3");
      repeat (2) @(negedge clk);
      check("R5 no fetch after last", 32'(fetch_req), 32'd0);
      reg_rd(8'h20, d);  check("R5 R3 R9 idle after chain", d, 32'h1021_0003);
      reg_rd(8'h24, d);  check("R8 perf cycle total", d, 32'(done_cyc - a_cyc));
   endtask

   task automatic t_ignored();
      logic [31:0] d;
      reg_wr(8'h00, 32'h8700_0000);
      repeat (4) @(negedge clk);
      check("R7 zero count no fetch", 32'(fetch_req), 32'd0);
      reg_rd(8'h00, d);  check("R7 zero count ctrl unchanged", d, 32'h5000_0003);
      reg_wr(8'h20, 32'hFFFF_FFFF);
      reg_wr(8'h24, 32'h0);
      reg_rd(8'h20, d);  check("R11 status hi write ignored", d, 32'h1021_0003);
      reg_rd(8'h24, d);  check("R11 perf write ignored", (d != 0) ? 32'd1 : 32'd0, 32'd1);
      reg_rd(8'h3C, d);  check("R11 unmapped reads zero", d, 32'h0);
   endtask

   task automatic t_loop();
      logic [31:0] d;
      int a_cyc;
      int first_end;
      reg_wr(8'h00, 32'h8000_0002);
      a_cyc = wr_cyc;
      check("R1 msi_tc loop header", 32'(msi_tc), 32'd0);
      serve_desc(1, "R2 loop d1");
      serve_desc(2, "R2 loop d2");
      first_end = done_cyc;
      serve_desc(1, "R6 loop restarts at d1");
      reg_rd(8'h20, d);  check("R6 still busy in loop", d, 32'h1020_0001);
      reg_wr(8'h00, 32'h0000_0007);
      reg_rd(8'h00, d);  check("R7 busy write keeps count", d, 32'h0000_0002);
      serve_desc(2, "R6 loop d2 after clear");
      repeat (3) @(negedge clk);
      check("R6 loop ended", 32'(fetch_req), 32'd0);
      reg_rd(8'h20, d);  check("R6 idle after loop clear", d, 32'h1021_0002);
      reg_rd(8'h24, d);  check("R8 perf frozen at first pass", d, 32'(first_end - a_cyc));
      reg_wr(8'h00, 32'h2000_0001);
      reg_rd(8'h20, d);  check("R3 last done cleared on accept", d, 32'h1020_0000);
      check("R1 msi_tc new header", 32'(msi_tc), 32'd2);
      reg_rd(8'h24, d);  check("R8 perf restarted", (d < 32'd8) ? 32'd1 : 32'd0, 32'd1);
      serve_desc(1, "R5 one-descriptor chain");
      repeat (2) @(negedge clk);
      reg_rd(8'h20, d);  check("R5 one-descriptor done", d, 32'h1021_0001);
   endtask

   task automatic t_ecrc();
      logic [31:0] d;
      @(negedge clk);
      ecrc_fwd_en = 1'b0; ecrc_err = 1'b1;
      repeat (5) @(negedge clk);
      ecrc_err = 1'b0;
      reg_rd(8'h30, d);  check("R10 disabled errors not counted", d, 32'h0);
      ecrc_fwd_en = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); ecrc_err = 1'b1;
         @(negedge clk); ecrc_err = 1'b0;
      end
      reg_rd(8'h30, d);  check("R10 ten error pulses", d, 32'd10);
      @(negedge clk); ecrc_err = 1'b1;
      repeat (65530) @(negedge clk);
      ecrc_err = 1'b0;
      reg_rd(8'h30, d);  check("R10 error count saturates", d, 32'h0000_FFFF);
      @(negedge clk); ecrc_err = 1'b1;
      repeat (3) @(negedge clk);
      ecrc_err = 1'b0;
      reg_rd(8'h30, d);  check("R10 stays saturated", d, 32'h0000_FFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single_pass();
      t_ignored();
      t_loop();
      t_ecrc();
      finished = 1'b1;
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

endmodule